// File: doc/BRIEF.md
# Bit-Field Extract/Insert Unit

This execution unit sits in the integer pipeline of a 32-bit processor and handles two immediate-form bit-field operations. It decodes the instruction word, then builds a field mask from the encoded position and size. It produces either a right-aligned copy of a field taken out of the source operand, or a copy of the current destination value with a field from the source written into it.

The caller presents the instruction word, the source operand, the present value of the destination register and a valid strobe. One clock later the unit presents a registered result, a write-enable and the destination register index. It raises an illegal-encoding flag, with no write-enable, when a recognised instruction carries field parameters that do not fit the word. Any other instruction word passes through silently, so the unit can see every issued instruction.

Top module: `bitfield_exu`

## Requirements
- R1: Extract: with size W and low position L, result bits W-1..0 equal source bits L+W-1..L and every result bit from W upward is zero.
- R2: Insert: with top index M and low position L, result bits M..L equal source bits M-L..0 and every other result bit equals the old destination value.
- R3: An instruction is recognised only when bits 31:26 equal 6'b011001. Bits 15:14 then pick the operation: 2'b01 is extract and 2'b10 is insert. Any other word gives neither write-enable nor illegal flag.
- R4: Field positions: bits 25:21 are the destination index and bits 4:0 are the low position L. Bits 10:6 are the size W for extract and the top bit index M for insert, so the insert size is M-L+1.
- R5: Outputs change on the clock edge that samples valid high. With valid low, the next cycle shows write-enable and illegal flag both low.
- R6: Extract is illegal, with flag high and write-enable low, when W is 0 or W+L exceeds 32. W+L equal to 32 is legal.
- R7: Insert is illegal, with flag high and write-enable low, when M is below L. M equal to L (a one-bit field) is legal.
- R8: Whenever write-enable is low, the result and destination index outputs are zero.
- R9: An active-high synchronous reset drives result, write-enable, destination index and illegal flag to zero.
- R10: Boundaries: insert with M=31 and L=0 replaces the whole word, and insert at M=L=31 changes only bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Instruction word and operands are present |
| instr | input | 32 | Instruction word |
| src_val | input | 32 | Source register value |
| dst_val | input | 32 | Current destination register value |
| result | output | 32 | Registered result |
| wr_en | output | 1 | Write the result to the destination register |
| rd_idx | output | 5 | Destination register index |
| illegal | output | 1 | Recognised instruction with out-of-range field |

## Verification
The assertions assume that the instruction, source and destination inputs hold known values at every clock edge where valid is high. They also assume that the destination value presented is the one the insert is meant to modify. The stimulus drives every input to a defined value from reset onward and changes inputs only on the falling edge. A reference model that walks the field bit by bit predicts each cycle's outputs. Random words are drawn mostly from the recognised opcode, with every selector value and with field parameters spread across legal and illegal ranges.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
    localparam int XLEN     = 32;
    localparam int SHW      = $clog2(XLEN);
    localparam int RIDX_W   = 5;
    localparam int MAJ_W    = 6;
    localparam int SEL_W    = 2;

    localparam int MAJ_LSB  = 26;
    localparam int RD_LSB   = 21;
    localparam int SEL_LSB  = 14;
    localparam int HI_LSB   = 6;
    localparam int LO_LSB   = 0;

    localparam logic [MAJ_W-1:0] MAJ_CODE = 6'h19;
    localparam logic [SEL_W-1:0] SEL_EXT  = 2'b01;
    localparam logic [SEL_W-1:0] SEL_INS  = 2'b10;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_EXTRACT = 2'd1,
        OP_INSERT  = 2'd2
    } bf_op_e;

    typedef struct packed {
        bf_op_e            op;
        logic              bad;
        logic [RIDX_W-1:0] rd;
        logic [SHW-1:0]    lo;
        logic [SHW:0]      width;
    } bf_ctl_t;

    function automatic logic [XLEN-1:0] field_mask(input logic [SHW:0] w,
                                                   input logic [SHW-1:0] lo);
        logic [2*XLEN-1:0] wide;
        wide = ((2*XLEN)'(1) << w) - (2*XLEN)'(1);
        wide = wide << lo;
        return wide[XLEN-1:0];
    endfunction
endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
    import bfx_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output bf_ctl_t         ctl
);
    logic [SHW-1:0]   hi_f;
    logic [SHW-1:0]   lo_f;
    logic [SEL_W-1:0] sel_f;
    logic             maj_hit;
    logic [SHW:0]     span_sum;

    assign hi_f     = instr[HI_LSB +: SHW];
    assign lo_f     = instr[LO_LSB +: SHW];
    assign sel_f    = instr[SEL_LSB +: SEL_W];
    assign maj_hit  = (instr[MAJ_LSB +: MAJ_W] == MAJ_CODE);
    assign span_sum = {1'b0, hi_f} + {1'b0, lo_f};

    always_comb begin
        ctl       = '0;
        ctl.rd    = instr[RD_LSB +: RIDX_W];
        ctl.lo    = lo_f;
        ctl.op    = OP_NONE;
        if (maj_hit && sel_f == SEL_EXT) begin
            ctl.op    = OP_EXTRACT;
            ctl.width = {1'b0, hi_f};
            ctl.bad   = (hi_f == '0) || (span_sum > (SHW+1)'(XLEN));
        end else if (maj_hit && sel_f == SEL_INS) begin
            ctl.op    = OP_INSERT;
            ctl.width = {1'b0, hi_f} - {1'b0, lo_f} + (SHW+1)'(1);
            ctl.bad   = (hi_f < lo_f);
        end
    end
endmodule

// File: rtl/bfx_mask.sv
module bfx_mask
    import bfx_pkg::*;
(
    input  logic [SHW:0]    width,
    input  logic [SHW-1:0]  lo,
    output logic [XLEN-1:0] mask
);
    assign mask = field_mask(width, lo);
endmodule

// File: rtl/bfx_merge.sv
module bfx_merge
    import bfx_pkg::*;
(
    input  bf_op_e          op,
    input  logic [SHW-1:0]  lo,
    input  logic [XLEN-1:0] mask,
    input  logic [XLEN-1:0] src_val,
    input  logic [XLEN-1:0] dst_val,
    output logic [XLEN-1:0] res
);
    logic [XLEN-1:0] ext_val;
    logic [XLEN-1:0] ins_val;

    assign ext_val = (src_val >> lo) & (mask >> lo);
    assign ins_val = (dst_val & ~mask) | ((src_val << lo) & mask);

    always_comb begin
        case (op)
            OP_EXTRACT: res = ext_val;
            OP_INSERT:  res = ins_val;
            default:    res = '0;
        endcase
    end
endmodule

// File: rtl/bitfield_exu.sv
module bitfield_exu
    import bfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [XLEN-1:0]   instr,
    input  logic [XLEN-1:0]   src_val,
    input  logic [XLEN-1:0]   dst_val,
    output logic [XLEN-1:0]   result,
    output logic              wr_en,
    output logic [RIDX_W-1:0] rd_idx,
    output logic              illegal
);
    bf_ctl_t         ctl;
    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] comb_res;
    logic            known;
    logic            accept;

    bfx_decode u_dec (
        .instr (instr),
        .ctl   (ctl)
    );

    bfx_mask u_mask (
        .width (ctl.width),
        .lo    (ctl.lo),
        .mask  (mask)
    );

    bfx_merge u_merge (
        .op      (ctl.op),
        .lo      (ctl.lo),
        .mask    (mask),
        .src_val (src_val),
        .dst_val (dst_val),
        .res     (comb_res)
    );

    assign known  = valid && (ctl.op != OP_NONE);
    assign accept = known && !ctl.bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            result  <= '0;
            wr_en   <= 1'b0;
            rd_idx  <= '0;
            illegal <= 1'b0;
        end else begin
            wr_en   <= accept;
            illegal <= known && ctl.bad;
            result  <= accept ? comb_res : '0;
            rd_idx  <= accept ? ctl.rd : '0;
        end
    end

    // R1: nothing survives above the extracted field
    a_r1_extract_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(ctl.op == OP_EXTRACT)) |-> ((result >> $past(ctl.width)) == '0));

    // R2: bits outside the inserted field come from the old destination
    a_r2_insert_keep: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(ctl.op == OP_INSERT)) |->
        ((result & ~$past(mask)) == ($past(dst_val) & ~$past(mask))));

    // R5: any output activity follows a valid strobe
    a_r5_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (wr_en || illegal) |-> $past(valid));

    // R6: an illegal encoding never writes
    a_r6_no_write_on_illegal: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !wr_en);

    // R7: a written insert had its top index at or above its low position
    a_r7_insert_order: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(ctl.op == OP_INSERT)) |->
        ($past(instr[HI_LSB +: SHW]) >= $past(instr[LO_LSB +: SHW])));

    // R8: idle outputs are zero
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> (result == '0 && rd_idx == '0));
endmodule

// File: tb/sim_bitfield_exu.sv
module sim_bitfield_exu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] src_val = '0;
    logic [31:0] dst_val = '0;
    logic [31:0] result;
    logic        wr_en;
    logic [4:0]  rd_idx;
    logic        illegal;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bitfield_exu u0 (
        .clk(clk), .rst(rst), .valid(valid), .instr(instr),
        .src_val(src_val), .dst_val(dst_val), .result(result),
        .wr_en(wr_en), .rd_idx(rd_idx), .illegal(illegal)
    );

    function automatic logic [31:0] enc(input logic [1:0] sel, input logic [4:0] rd,
                                        input logic [4:0] hi, input logic [4:0] lo);
        return {6'h19, rd, 5'd3, sel, 3'b000, hi, 1'b0, lo};
    endfunction

    task automatic model(input logic [31:0] ins, input logic [31:0] s, input logic [31:0] d,
                         input logic v, output logic e_we, output logic e_ill,
                         output logic [4:0] e_rd, output logic [31:0] e_res);
        int hi = int'(ins[10:6]);
        int lo = int'(ins[4:0]);
        e_we = 0; e_ill = 0; e_rd = '0; e_res = '0;
        if (v && ins[31:26] == 6'h19) begin
            if (ins[15:14] == 2'b01) begin
                if (hi == 0 || hi + lo > 32) e_ill = 1;
                else begin
                    e_we = 1;
                    for (int i = 0; i < hi; i++) e_res[i] = s[lo + i];
                end
            end else if (ins[15:14] == 2'b10) begin
                if (hi < lo) e_ill = 1;
                else begin
                    e_we = 1;
                    e_res = d;
                    for (int i = lo; i <= hi; i++) e_res[i] = s[i - lo];
                end
            end
        end
        if (e_we) e_rd = ins[25:21];
    endtask

    task automatic check(input string tag, input logic e_we, input logic e_ill,
                         input logic [4:0] e_rd, input logic [31:0] e_res);
        total++;
        if (wr_en !== e_we || illegal !== e_ill || rd_idx !== e_rd || result !== e_res) begin
            bad++;
            $display("FAIL %s: got we=%0b ill=%0b rd=%0d res=%h exp we=%0b ill=%0b rd=%0d res=%h",
                     tag, wr_en, illegal, rd_idx, result, e_we, e_ill, e_rd, e_res);
        end
    endtask

    task automatic step(input string tag, input logic v, input logic [31:0] ins,
                        input logic [31:0] s, input logic [31:0] d);
        logic e_we, e_ill;
        logic [4:0] e_rd;
        logic [31:0] e_res;
        @(negedge clk);
        valid = v; instr = ins; src_val = s; dst_val = d;
        model(ins, s, d, v, e_we, e_ill, e_rd, e_res);
        @(posedge clk);
        #1;
        check(tag, e_we, e_ill, e_rd, e_res);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset", 0, 0, 5'd0, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        step("R1 extract w8 l4", 1, enc(2'b01, 5'd7, 5'd8, 5'd4), 32'hDEADBEEF, 32'h0);
        step("R1 R6 extract w31 l1 edge", 1, enc(2'b01, 5'd2, 5'd31, 5'd1), 32'hFFFF_FFFF, 32'h0);
        step("R6 extract w0", 1, enc(2'b01, 5'd9, 5'd0, 5'd3), 32'h1234_5678, 32'h0);
        step("R6 extract w+l 33", 1, enc(2'b01, 5'd9, 5'd30, 5'd3), 32'h1234_5678, 32'h0);
        step("R2 insert m15 l8", 1, enc(2'b10, 5'd4, 5'd15, 5'd8), 32'h0000_00A5, 32'hFFFF_FFFF);
        step("R7 insert m=l", 1, enc(2'b10, 5'd5, 5'd12, 5'd12), 32'h1, 32'h0);
        step("R7 insert m<l", 1, enc(2'b10, 5'd5, 5'd3, 5'd4), 32'h1, 32'h0);
        step("R10 insert full word", 1, enc(2'b10, 5'd31, 5'd31, 5'd0), 32'hCAFE_F00D, 32'h1111_1111);
        step("R10 insert top bit", 1, enc(2'b10, 5'd1, 5'd31, 5'd31), 32'h0000_0001, 32'h0F0F_0F0F);
        step("R3 selector 00", 1, enc(2'b00, 5'd6, 5'd8, 5'd0), 32'hFFFF_FFFF, 32'h0);
        step("R3 selector 11", 1, enc(2'b11, 5'd6, 5'd8, 5'd0), 32'hFFFF_FFFF, 32'h0);
        step("R3 wrong major", 1, enc(2'b01, 5'd6, 5'd8, 5'd0) ^ 32'h0400_0000, 32'hFFFF_FFFF, 32'h0);
        step("R5 R8 valid low", 0, enc(2'b01, 5'd6, 5'd8, 5'd0), 32'hFFFF_FFFF, 32'h0);
        step("R4 rd field", 1, enc(2'b01, 5'd19, 5'd4, 5'd28), 32'hA000_0000, 32'h0);

        for (int n = 0; n < 3000; n++) begin
            logic [31:0] ins = $urandom;
            if ($urandom_range(0, 4) != 0) ins[31:26] = 6'h19;
            step("R1 R2 R3 R5 random", $urandom_range(0, 5) != 0, ins, $urandom, $urandom);
        end

        @(negedge clk);
        rst = 1'b1; valid = 1'b1; instr = enc(2'b01, 5'd3, 5'd4, 5'd0);
        @(posedge clk);
        #1;
        check("R9 reset mid-run", 0, 0, 5'd0, 32'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule